// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block runs in the 32 kHz timekeeping clock domain and controls power for the rest of the chip. Software writes a command to put the system into hibernate, and the power-enable output then drops. While hibernating, the block watches an external wakeup pin. It resumes power only after the pin has stayed asserted for a programmable number of ticks, so short glitches and accidental presses do not wake the system.

Once wakeup is accepted, power is restored at once. The active-low system reset is held for a second programmable number of ticks so that supplies and oscillators can settle, and then it is released.

Both durations are tick counts in which only the upper bits are kept and the five lowest bits always read as zero. At 32 kHz the debounce window reaches about 2 s and the reset hold about 125 ms. Typical settings are about 100 ms of debounce and about 60 ms of reset hold.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset the block is awake: `pwr_en_o` = 1 and `sys_rst_no` = 1.
- R2: A write to word address 0 with bit 0 set, while awake, starts hibernate. `pwr_en_o` and `sys_rst_no` are both 0 from the clock edge that takes the write. A write to the same address with bit 0 clear has no effect.
- R3: A write to word address 1 sets the debounce count T to the written bits [FILT_W-1:5], with the five low bits of T zero. All other written bits are ignored.
- R4: A write to word address 2 sets the reset hold count H to the written bits [RST_W-1:5], with the five low bits of H zero. All other written bits are ignored.
- R5: The wakeup pin reaches the debounce logic through a two-flop synchronizer. Wakeup is accepted after max(T,1) consecutive synchronized high samples. `pwr_en_o` rises max(T,1)+2 clock edges after the pin rises.
- R6: If the synchronized pin goes low before the count is reached, the debounce count restarts from zero. A later assertion must then last the full window again.
- R7: After `pwr_en_o` rises, `sys_rst_no` stays low for max(H,1) clock edges and then goes high.
- R8: While awake, the wakeup pin has no effect on either output.
- R9: The states follow the order awake, hibernate, debounce, reset hold, awake. `sys_rst_no` is never high while `pwr_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 kHz timekeeping clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Word address: 0 command, 1 debounce count, 2 reset hold count |
| wr_data_i | input | 32 | Write data |
| wake_pin_i | input | 1 | Asynchronous wakeup pin, active high |
| pwr_en_o | output | 1 | Power enable for the switched domain |
| sys_rst_no | output | 1 | Active-low system reset |

## Verification
The bench sweeps every debounce setting and every reset hold setting of a narrowed configuration, including the zero settings. At zero, a design that waits one cycle too long or too short, or that treats zero as a full wrap, gives latencies that are off by one or by a large amount. Every write also carries ones in the ignored bits, so a design that stores unmasked bits shows very different latencies. A short pin pulse followed by a full assertion catches a counter that pauses instead of restarting: such a design would wake early. Pin activity while awake and a command write with bit 0 clear must leave both outputs high, which catches a design that forces hibernate or reset on its own.

// File: rtl/hib_pkg.sv
package hib_pkg;
  localparam int ADDR_W = 2;
  localparam int FRAC_W = 5;  // low bits of every tick count forced to zero

  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_FILT = 2'd1;
  localparam logic [ADDR_W-1:0] A_HOLD = 2'd2;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_HIB   = 2'd1,
    ST_FILT  = 2'd2,
    ST_HOLD  = 2'd3
  } hib_state_e;
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/hib_cfg_regs.sv
module hib_cfg_regs
  import hib_pkg::*;
#(
  parameter int FILT_W     = 16,
  parameter int RST_W      = 12,
  parameter int FILT_RESET = 3264,
  parameter int HOLD_RESET = 1952
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [FILT_W-1:0] filt_thr_o,
  output logic [RST_W-1:0]  hold_thr_o
);
  localparam int FF_W = FILT_W - FRAC_W;
  localparam int HF_W = RST_W - FRAC_W;
  localparam logic [31:0] FILT_RST32 = 32'(FILT_RESET);
  localparam logic [31:0] HOLD_RST32 = 32'(HOLD_RESET);

  logic [FF_W-1:0] filt_q;
  logic [HF_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= FILT_RST32[FILT_W-1:FRAC_W];
      hold_q <= HOLD_RST32[RST_W-1:FRAC_W];
    end else if (wr_en_i) begin
      if (wr_addr_i == A_FILT) filt_q <= wr_data_i[FILT_W-1:FRAC_W];
      if (wr_addr_i == A_HOLD) hold_q <= wr_data_i[RST_W-1:FRAC_W];
    end
  end

  assign filt_thr_o = {filt_q, {FRAC_W{1'b0}}};
  assign hold_thr_o = {hold_q, {FRAC_W{1'b0}}};
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_hib_i,
  input  logic             wake_i,
  input  logic [CNT_W-1:0] filt_thr_i,
  input  logic [CNT_W-1:0] hold_thr_i,
  output hib_state_e       state_o
);
  hib_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: begin
        cnt_d = '0;
        if (cmd_hib_i) state_d = ST_HIB;
      end
      ST_HIB, ST_FILT: begin
        if (!wake_i) begin
          state_d = ST_HIB;
          cnt_d   = '0;
        end else if (cnt_inc >= filt_thr_i) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end else begin
          state_d = ST_FILT;
          cnt_d   = cnt_inc;
        end
      end
      ST_HOLD: begin
        if (cnt_inc >= hold_thr_i) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        state_d = ST_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  // R6
  filt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILT && !wake_i) |=> (state_q == ST_HIB && cnt_q == '0));

  // R5
  wake_needs_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_HOLD) ##1 (state_q == ST_HOLD) |-> $past(wake_i));

  // R9
  order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |=> (state_q == ST_HOLD || state_q == ST_AWAKE));
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq
  import hib_pkg::*;
#(
  parameter int FILT_W     = 16,
  parameter int RST_W      = 12,
  parameter int FILT_RESET = 3264,
  parameter int HOLD_RESET = 1952
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              wake_pin_i,
  output logic              pwr_en_o,
  output logic              sys_rst_no
);
  localparam int CNT_W = (FILT_W > RST_W) ? FILT_W : RST_W;

  logic              wake_s;
  logic [FILT_W-1:0] filt_thr;
  logic [RST_W-1:0]  hold_thr;
  logic              cmd_hib;
  hib_state_e        state;

  hib_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wake_pin_i),
    .q_o   (wake_s)
  );

  hib_cfg_regs #(
    .FILT_W    (FILT_W),
    .RST_W     (RST_W),
    .FILT_RESET(FILT_RESET),
    .HOLD_RESET(HOLD_RESET)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .filt_thr_o(filt_thr),
    .hold_thr_o(hold_thr)
  );

  assign cmd_hib = wr_en_i && (wr_addr_i == A_CMD) && wr_data_i[0];

  hib_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_hib_i (cmd_hib),
    .wake_i    (wake_s),
    .filt_thr_i(CNT_W'(filt_thr)),
    .hold_thr_i(CNT_W'(hold_thr)),
    .state_o   (state)
  );

  assign pwr_en_o   = (state == ST_AWAKE) || (state == ST_HOLD);
  assign sys_rst_no = (state == ST_AWAKE);

  // R9
  rst_needs_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no |-> pwr_en_o);

  // R2
  hib_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && cmd_hib) |=> (!pwr_en_o && !sys_rst_no));

  // R7
  release_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> $past(pwr_en_o));
endmodule

// File: tb/hib_wake_seq_bench.sv
module hib_wake_seq_bench;
  localparam int FW = 9;
  localparam int RW = 8;
  localparam logic [31:0] FMASK = ((32'd1 << FW) - 1) & ~32'd31;
  localparam logic [31:0] HMASK = ((32'd1 << RW) - 1) & ~32'd31;
  localparam logic [31:0] JUNK  = 32'hDEAD_BE1F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pin = 1'b0;
  logic        pwr_en, sys_rst_n;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  hib_wake_seq #(.FILT_W(FW), .RST_W(RW), .FILT_RESET(96), .HOLD_RESET(64)) u_hib_wake_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wake_pin_i(pin), .pwr_en_o(pwr_en), .sys_rst_no(sys_rst_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // edges after pin rise until pwr_en high
  task automatic wait_pwr(output int k);
    k = 0;
    do begin
      @(posedge clk); #1; k++;
    end while (!pwr_en && k < 5000);
  endtask

  task automatic wait_rel(output int k);
    k = 0;
    do begin
      @(posedge clk); #1; k++;
    end while (!sys_rst_n && k < 5000);
  endtask

  task automatic run_case(input int tf, input int hf);
    int t, h, k;
    t = tf * 32; h = hf * 32;
    // R3 R4: junk in ignored bits
    wr(2'd1, (JUNK & ~FMASK) | (32'(tf) << 5));
    wr(2'd2, (JUNK & ~HMASK) | (32'(hf) << 5));
    wr(2'd0, 32'h1);
    // R2
    chk("R2 pwr off", int'(pwr_en), 0);
    chk("R2 rst low", int'(sys_rst_n), 0);
    idle(4);
    chk("R5 no wake w/o pin", int'(pwr_en), 0);
    pin = 1'b1;
    wait_pwr(k);
    chk("R3 R5 wake latency", k, ((t < 1) ? 1 : t) + 2);
    chk("R9 rst low at wake", int'(sys_rst_n), 0);
    wait_rel(k);
    chk("R4 R7 hold length", k, (h < 1) ? 1 : h);
    chk("R9 pwr on at release", int'(pwr_en), 1);
    pin = 1'b0;
    idle(3);
  endtask

  initial begin
    int k;
    #1;
    chk("R1 pwr", int'(pwr_en), 1);
    chk("R1 rst", int'(sys_rst_n), 1);
    idle(2);
    rst_n = 1'b1;
    idle(2);
    chk("R1 pwr after reset", int'(pwr_en), 1);
    chk("R1 rst after reset", int'(sys_rst_n), 1);

    // R8: pin while awake
    pin = 1'b1; idle(20);
    chk("R8 pwr", int'(pwr_en), 1);
    chk("R8 rst", int'(sys_rst_n), 1);
    pin = 1'b0; idle(3);

    // R2: bit 0 clear is no command
    wr(2'd0, 32'hFFFF_FFFE);
    idle(2);
    chk("R2 cmd bit0 clear pwr", int'(pwr_en), 1);
    chk("R2 cmd bit0 clear rst", int'(sys_rst_n), 1);

    // sweep all debounce and hold fields
    for (int i = 0; i < 16; i++) run_case(i, (i * 3) % 8);
    run_case(15, 7);

    // R6: short pulse restarts the count
    wr(2'd1, 32'(2) << 5);
    wr(2'd2, 32'(1) << 5);
    wr(2'd0, 32'h1);
    pin = 1'b1; idle(40);
    chk("R6 short pulse no wake", int'(pwr_en), 0);
    pin = 1'b0; idle(5);
    chk("R6 still asleep", int'(pwr_en), 0);
    pin = 1'b1;
    wait_pwr(k);
    chk("R6 full window after restart", k, 66);
    wait_rel(k);
    chk("R7 hold after restart", k, 32);
    pin = 1'b0; idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule